// File: doc/BRIEF.md
# Change-Event Interrupt Register Bank

This block sits beside a video decoder core and turns changes on its status outputs into interrupts. It watches six sources: the 50/60 Hz output frame-rate flag, vertical sync lock, horizontal sync lock, a 3-bit autodetected-standard code, SECAM lock and PAL swinging-burst lock. When any of them changes value, in either direction, a matching sticky status bit is set. The bit stays set until software clears it.

Software reaches three byte-wide registers through a simple register bus. Writes take effect on the clock edge. Reads are combinational from the current address.

- The status register is read-only and sits at the base address.
- The clear register is write-only and sits at base+1. Writing a 1 to a bit clears that status bit.
- The mask register is read/write and sits at base+2. A 1 in a mask bit lets the matching status bit raise the interrupt request.

The single request output is high whenever any set status bit is also enabled in the mask.

Top module: `chg_irq_bank`

## Requirements
- R1: Status bit positions are fixed: bit 0 frame-rate flag, bit 1 vertical lock, bit 2 horizontal lock, bit 3 autodetect code, bit 4 SECAM lock, bit 5 PAL swinging-burst lock. A read of the status register (base address, default 0x4A) returns them, with bits 7:6 reading 0.
- R2: A change of any single-bit source, rising or falling, sets its status bit. The bit is visible after the clock edge at which the new value is first sampled.
- R3: Any change of the 3-bit autodetect code sets status bit 3, whether one bit or several bits of the code change.
- R4: Status bits are sticky. They stay set while their source is stable, and no status bit becomes set without a change on its source.
- R5: Writing the clear register (base+1) clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged. A read of the clear register returns 0.
- R6: When a change on a source and a clear of its status bit fall in the same cycle, the status bit ends up set.
- R7: The mask register (base+2) stores write-data bits 5:0. Bits 7:6 are ignored on write and read as 0.
- R8: The request `irq` is high exactly when some status bit is set and its mask bit is 1. Mask bits do not alter the status bits themselves.
- R9: Synchronous active-low reset clears all status and mask bits and drives `irq` low. Source values present during reset do not produce a status bit after reset is released.
- R10: A read from any address outside the three registers returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_rate_in | input | 1 | Output 50/60 Hz frame-rate flag from the decoder |
| vlock_in | input | 1 | Vertical sync lock level |
| hlock_in | input | 1 | Horizontal sync lock level |
| ad_result_in | input | 3 | Autodetected video standard code |
| secam_lock_in | input | 1 | SECAM lock level |
| palsw_lock_in | input | 1 | PAL swinging-burst lock level |
| bus_addr | input | 8 | Register address |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request, high while an unmasked status bit is set |

## Verification
The assertions assume that every source input is already synchronous to `clk` and holds a defined value from the first clock edge of reset. That way, the previous-value copy taken on each edge is a valid reference for change detection. They also assume that a write strobe is a single cycle carrying a stable address and data. The bench drives all sources and bus signals only on the falling clock edge. It holds reset for several cycles at the start, and it always raises the strobe for exactly one cycle. Every source change is therefore one clean sampled transition, which the reference model sees in the same cycle as the block.

// File: rtl/chg_irq_pkg.sv
// Package: shared widths, event bit positions and register offsets for the
// change-event interrupt bank. Bit positions are decoded by software and so
// are fixed; the offsets are relative to the bank base address.
package chg_irq_pkg;
    localparam int NUM_EVT = 6;            // event sources / status bits
    localparam int NUM_LVL = NUM_EVT - 1;  // single-bit level sources
    localparam int AD_W    = 3;            // autodetect code width
    localparam int REG_W   = 8;            // register data width
    localparam int ADDR_W  = 8;            // register address width

    localparam int EVT_FRAME = 0;
    localparam int EVT_VLOCK = 1;
    localparam int EVT_HLOCK = 2;
    localparam int EVT_AD    = 3;
    localparam int EVT_SECAM = 4;
    localparam int EVT_PALSW = 5;

    localparam int OFS_STAT = 0;
    localparam int OFS_CLR  = 1;
    localparam int OFS_MASK = 2;
endpackage

// File: rtl/chg_detect.sv
// Module: chg_detect
// Flags a change on a W-bit source by comparing it with a copy registered on
// the previous clock. Assumes the source is synchronous to clk. The copy loads
// the source on every edge, including reset edges, so leaving reset never
// produces a false change.
module chg_detect #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] sig_in,
    output logic         changed
);
    logic [W-1:0] prev_q;

    // Keep last cycle's value of the source.
    always_ff @(posedge clk) begin
        prev_q <= sig_in;
    end

    // Any differing bit is a change.
    always_comb begin
        changed = (sig_in != prev_q);
    end
endmodule

// File: rtl/sticky_status.sv
// Module: sticky_status
// N sticky status bits. A set request wins over a clear request for the same
// bit in the same cycle, so no event is lost. Synchronous active-low reset.
module sticky_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] status_q
);
    // Clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/bank_regs.sv
// Module: bank_regs
// Register-bus decode for the bank: holds the mask register, produces the
// one-cycle clear vector, and muxes read data. Reserved bits and the
// write-only clear register read as 0. Assumes a one-cycle write strobe.
module bank_regs
    import chg_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h4A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wen,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic [NUM_EVT-1:0] status_q,
    output logic [NUM_EVT-1:0] clr_vec,
    output logic [NUM_EVT-1:0] mask_q,
    output logic [REG_W-1:0]   bus_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_STAT = BASE_ADDR + ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] ADDR_CLR  = BASE_ADDR + ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] ADDR_MASK = BASE_ADDR + ADDR_W'(OFS_MASK);
    localparam int               RSV_W     = REG_W - NUM_EVT;

    logic sel_clr;
    logic sel_mask;
    logic unused_rsvd;

    // Address decode for the write side.
    always_comb begin
        sel_clr  = bus_wen && (bus_addr == ADDR_CLR);
        sel_mask = bus_wen && (bus_addr == ADDR_MASK);
        clr_vec  = sel_clr ? bus_wdata[NUM_EVT-1:0] : '0;
    end

    // Reserved write-data bits have no function.
    assign unused_rsvd = ^bus_wdata[REG_W-1:NUM_EVT];

    // Mask register: 1 enables a source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (sel_mask) begin
            mask_q <= bus_wdata[NUM_EVT-1:0];
        end
    end

    // Read data mux; anything not readable returns 0.
    always_comb begin
        if (bus_addr == ADDR_STAT) begin
            bus_rdata = {{RSV_W{1'b0}}, status_q};
        end else if (bus_addr == ADDR_MASK) begin
            bus_rdata = {{RSV_W{1'b0}}, mask_q};
        end else begin
            bus_rdata = '0;
        end
    end
endmodule

// File: rtl/chg_irq_bank.sv
// Module: chg_irq_bank (top)
// Watches six decoder status sources, latches any change into sticky status
// bits, exposes status/clear/mask registers on a simple register bus and
// drives one interrupt request from the unmasked status bits.
// Assumes all sources are synchronous to clk.
module chg_irq_bank
    import chg_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h4A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_rate_in,
    input  logic              vlock_in,
    input  logic              hlock_in,
    input  logic [AD_W-1:0]   ad_result_in,
    input  logic              secam_lock_in,
    input  logic              palsw_lock_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [NUM_LVL-1:0] lvl_vec;
    logic [NUM_LVL-1:0] lvl_chg;
    logic               ad_chg;
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] mask_q;

    // Gather the single-bit sources (status order, autodetect excluded).
    assign lvl_vec = {palsw_lock_in, secam_lock_in, hlock_in, vlock_in, frame_rate_in};

    // One change detector per single-bit source.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        chg_detect #(.W(1)) u_det (
            .clk     (clk),
            .sig_in  (lvl_vec[g]),
            .changed (lvl_chg[g])
        );
    end

    // Multi-bit detector for the autodetect code.
    chg_detect #(.W(AD_W)) u_ad_det (
        .clk     (clk),
        .sig_in  (ad_result_in),
        .changed (ad_chg)
    );

    // Place events at their status bit positions.
    always_comb begin
        evt_vec            = '0;
        evt_vec[EVT_FRAME] = lvl_chg[0];
        evt_vec[EVT_VLOCK] = lvl_chg[1];
        evt_vec[EVT_HLOCK] = lvl_chg[2];
        evt_vec[EVT_AD]    = ad_chg;
        evt_vec[EVT_SECAM] = lvl_chg[3];
        evt_vec[EVT_PALSW] = lvl_chg[4];
    end

    sticky_status #(.N(NUM_EVT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (evt_vec),
        .clr_vec  (clr_vec),
        .status_q (status_q)
    );

    bank_regs #(.BASE_ADDR(BASE_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .status_q  (status_q),
        .clr_vec   (clr_vec),
        .mask_q    (mask_q),
        .bus_rdata (bus_rdata)
    );

    // Interrupt request from the enabled status bits.
    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/chg_irq_bank_chk.sv
// Module: chg_irq_bank_chk
// Property checker bound into chg_irq_bank. It keeps its own registered copy
// of the sources to derive change events independently of the design.
module chg_irq_bank_chk
    import chg_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h4A
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_rate_in,
    input logic               vlock_in,
    input logic               hlock_in,
    input logic [AD_W-1:0]    ad_result_in,
    input logic               secam_lock_in,
    input logic               palsw_lock_in,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wen,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic               irq,
    input logic [NUM_EVT-1:0] status_q,
    input logic [NUM_EVT-1:0] mask_q
);
    localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = BASE_ADDR + ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_MASK = BASE_ADDR + ADDR_W'(OFS_MASK);

    logic [NUM_EVT-1:0] src_now;
    logic [AD_W-1:0]    ad_now;
    logic [NUM_EVT-1:0] src_prev;
    logic [AD_W-1:0]    ad_prev;
    logic [NUM_EVT-1:0] chg;
    logic [NUM_EVT-1:0] clr_req;
    logic [NUM_EVT-1:0] clr_only;
    logic               mask_wr;

    // Checker-side snapshot of the sources.
    assign src_now = {palsw_lock_in, secam_lock_in, 1'b0, hlock_in, vlock_in, frame_rate_in};
    assign ad_now  = ad_result_in;

    // Previous-cycle copy held by the checker.
    always_ff @(posedge clk) begin
        src_prev <= src_now;
        ad_prev  <= ad_now;
    end

    // Events and bus requests as seen at the ports.
    always_comb begin
        chg         = src_now ^ src_prev;
        chg[EVT_AD] = (ad_now != ad_prev);
        clr_req     = (bus_wen && bus_addr == A_CLR) ? bus_wdata[NUM_EVT-1:0] : '0;
        clr_only    = clr_req & ~chg;
        mask_wr     = bus_wen && (bus_addr == A_MASK);
    end

    // R2/R3/R6: a change always leaves its status bit set, even against a clear.
    assert_set_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((status_q & $past(chg)) == $past(chg)));

    // R4: no bit rises without a change on its source.
    assert_no_false_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(chg)) == '0));

    // R4: a set bit only falls through a clear request.
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_req) & ~status_q) == '0));

    // R5: a clear with no competing change empties the bit.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_only != '0) |=> ((status_q & $past(clr_only)) == '0));

    // R7: a mask write stores the low data bits.
    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(bus_wdata[NUM_EVT-1:0])));

    // R1/R7: reserved read bits are zero.
    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT || bus_addr == A_MASK) |-> (bus_rdata[REG_W-1:NUM_EVT] == '0));

    // R8: an unmasked event raises the request next cycle.
    assert_irq_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((chg & mask_q) != '0) && !mask_wr) |=> irq);

    // R8: a fully closed mask keeps the request low.
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R9: reset empties status and mask.
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && mask_q == '0));
endmodule

bind chg_irq_bank chg_irq_bank_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_rate_in (frame_rate_in),
    .vlock_in      (vlock_in),
    .hlock_in      (hlock_in),
    .ad_result_in  (ad_result_in),
    .secam_lock_in (secam_lock_in),
    .palsw_lock_in (palsw_lock_in),
    .bus_addr      (bus_addr),
    .bus_wen       (bus_wen),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq           (irq),
    .status_q      (status_q),
    .mask_q        (mask_q)
);

// File: tb/chg_irq_bank_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed
// checks per requirement. Inputs change on the falling edge only.
module chg_irq_bank_bench;
    localparam logic [7:0] A_STAT = 8'h4A;
    localparam logic [7:0] A_CLR  = 8'h4B;
    localparam logic [7:0] A_MASK = 8'h4C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_rate = 1'b0;
    logic       vlock = 1'b1;
    logic       hlock = 1'b0;
    logic [2:0] ad_res = 3'd5;
    logic       secam_lock = 1'b1;
    logic       palsw_lock = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wen = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference model state.
    bit [5:0] m_status;
    bit [5:0] m_mask;
    bit [4:0] m_prev_lvl;
    bit [2:0] m_prev_ad;

    always #2.5 clk = ~clk;

    chg_irq_bank u_chg_irq_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_rate_in (frame_rate),
        .vlock_in      (vlock),
        .hlock_in      (hlock),
        .ad_result_in  (ad_res),
        .secam_lock_in (secam_lock),
        .palsw_lock_in (palsw_lock),
        .bus_addr      (bus_addr),
        .bus_wen       (bus_wen),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq           (irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == A_STAT) return {2'b00, m_status};
        if (a == A_MASK) return {2'b00, m_mask};
        return 8'h00;
    endfunction

    // Reference model step and per-clock comparison.
    always @(posedge clk) begin
        bit [4:0] lvl;
        bit [5:0] ev;
        lvl = {palsw_lock, secam_lock, hlock, vlock, frame_rate};
        if (!rst_n) begin
            m_status = '0;
            m_mask   = '0;
        end else begin
            ev = '0;
            ev[0] = lvl[0] != m_prev_lvl[0];
            ev[1] = lvl[1] != m_prev_lvl[1];
            ev[2] = lvl[2] != m_prev_lvl[2];
            ev[3] = ad_res != m_prev_ad;
            ev[4] = lvl[3] != m_prev_lvl[3];
            ev[5] = lvl[4] != m_prev_lvl[4];
            if (bus_wen && bus_addr == A_CLR) m_status = m_status & ~bus_wdata[5:0];
            m_status = m_status | ev;
            if (bus_wen && bus_addr == A_MASK) m_mask = bus_wdata[5:0];
        end
        m_prev_lvl = lvl;
        m_prev_ad  = ad_res;
        #1;
        chk({7'd0, irq}, {7'd0, |(m_status & m_mask)}, "R8 per-clock irq");
        chk(bus_rdata, model_read(bus_addr), "R1/R5/R7/R10 per-clock read");
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, req);
    endtask

    task automatic irq_chk(input logic exp, input string req);
        @(negedge clk);
        #1;
        chk({7'd0, irq}, {7'd0, exp}, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #500000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        rd_chk(A_STAT, 8'h00, "R9 status after reset");
        rd_chk(A_MASK, 8'h00, "R9 mask after reset");
        irq_chk(1'b0, "R9 irq after reset");
        idle(3);
        rd_chk(A_STAT, 8'h00, "R4 stable sources set nothing");

        wr(A_MASK, 8'hFF);
        rd_chk(A_MASK, 8'h3F, "R7 reserved mask bits ignored");

        @(negedge clk) vlock = 1'b0;
        rd_chk(A_STAT, 8'h02, "R2 vlock falling");
        irq_chk(1'b1, "R8 unmasked event raises irq");
        wr(A_CLR, 8'h00);
        rd_chk(A_STAT, 8'h02, "R5 clear with zero keeps bit");
        wr(A_CLR, 8'h02);
        rd_chk(A_STAT, 8'h00, "R5 clear with one");
        irq_chk(1'b0, "R8 irq drops after clear");

        @(negedge clk) hlock = 1'b1;
        rd_chk(A_STAT, 8'h04, "R2 hlock rising");
        wr(A_CLR, 8'h04);
        @(negedge clk) hlock = 1'b0;
        rd_chk(A_STAT, 8'h04, "R2 hlock falling");
        wr(A_CLR, 8'h3F);

        @(negedge clk) ad_res = 3'd4;
        rd_chk(A_STAT, 8'h08, "R3 autodetect one-bit change");
        wr(A_CLR, 8'h08);
        @(negedge clk) ad_res = 3'd3;
        rd_chk(A_STAT, 8'h08, "R3 autodetect multi-bit change");
        wr(A_CLR, 8'h08);
        idle(2);
        rd_chk(A_STAT, 8'h00, "R3 steady code sets nothing");

        @(negedge clk) frame_rate = 1'b1;
        rd_chk(A_STAT, 8'h01, "R1 frame-rate at bit 0");
        @(negedge clk) secam_lock = 1'b0;
        rd_chk(A_STAT, 8'h11, "R1 SECAM at bit 4");
        @(negedge clk) palsw_lock = 1'b1;
        rd_chk(A_STAT, 8'h31, "R1 PAL swing at bit 5");
        idle(5);
        rd_chk(A_STAT, 8'h31, "R4 bits stay set");
        wr(A_CLR, 8'h3F);
        rd_chk(A_STAT, 8'h00, "R5 clear all");

        @(negedge clk);
        secam_lock = 1'b1;
        bus_addr = A_CLR; bus_wdata = 8'h10; bus_wen = 1'b1;
        @(negedge clk) bus_wen = 1'b0;
        rd_chk(A_STAT, 8'h10, "R6 set wins over clear");
        wr(A_CLR, 8'h10);

        wr(A_MASK, 8'h00);
        @(negedge clk) frame_rate = 1'b0;
        rd_chk(A_STAT, 8'h01, "R8 mask leaves status intact");
        irq_chk(1'b0, "R8 masked bit gives no irq");
        wr(A_MASK, 8'h01);
        irq_chk(1'b1, "R8 unmask raises irq");
        wr(A_MASK, 8'h3E);
        irq_chk(1'b0, "R8 other mask bits do not pass bit 0");

        rd_chk(A_CLR, 8'h00, "R5 clear register reads 0");
        rd_chk(8'h00, 8'h00, "R10 unmapped address reads 0");
        rd_chk(8'h4D, 8'h00, "R10 address above bank reads 0");

        @(negedge clk) begin rst_n = 1'b0; vlock = ~vlock; end
        @(negedge clk) ad_res = 3'd1;
        @(negedge clk) rst_n = 1'b1;
        rd_chk(A_STAT, 8'h00, "R9 reset clears status, no false event");
        rd_chk(A_MASK, 8'h00, "R9 reset clears mask");
        irq_chk(1'b0, "R9 irq low after reset");

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule